// File: doc/BRIEF.md
# Synchronous Up/Down Toggle Counter

This block is a binary counter whose state bits are toggle-style: on every clock edge each bit either stays or flips, and no bit is ever clocked by another bit's output. All bits share one clock. Two separate direction inputs pick the action for each edge. With `countUp` high the value goes up by one. With only `countDown` high it goes down by one. With neither high it holds. When both are high, counting up wins.

The toggle enable of every bit above bit 0 comes from the bits below it. When counting up it uses their true values, and when counting down it uses their complements. A combinational terminal-count flag tells the surrounding logic that the next edge will wrap the value. Instances can be chained or used as event counters through this flag.

Top module: `updn_toggle_counter`

## Requirements
- R1: A synchronous active-high `rst` forces `count` to 0 on the next rising edge, and it takes precedence over both direction inputs.
- R2: With `countUp`=1 and `countDown`=0, `count` becomes (count+1) mod 2^WIDTH at each rising edge.
- R3: With `countUp`=0 and `countDown`=1, `count` becomes (count-1) mod 2^WIDTH at each rising edge.
- R4: With both direction inputs 0, `count` keeps its value across the edge.
- R5: With both direction inputs 1, the counter increments, exactly as in R2.
- R6: While counting in either direction, bit 0 of `count` flips at every edge.
- R7: When counting up, bit i (i>0) flips only if bits 0..i-1 are all 1. When counting down, bit i flips only if bits 0..i-1 are all 0.
- R8: `termCount` is 1 exactly when counting up with `count` all ones, or when counting down (`countUp`=0, `countDown`=1) with `count` all zeros. It is 0 when holding. It is combinational, so it reflects the current inputs and state in the same cycle.
- R9: Counting up from all ones wraps to 0. Counting down from 0 wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all state bits |
| rst | input | 1 | Synchronous active-high reset to zero |
| countUp | input | 1 | Count-up request; has priority |
| countDown | input | 1 | Count-down request |
| count | output | WIDTH | Current count value |
| termCount | output | 1 | Next edge will wrap the count |

## Verification
A wrong toggle enable on any bit shows up as an incorrect `count` one edge after the mis-enabled step. High-order bits are only exercised at carry or borrow boundaries, so a fault there stays hidden until the low bits reach all ones or all zeros. This can take up to 2^WIDTH edges. The bench therefore runs long monotonic stretches in both directions through both wrap points, in addition to random direction changes. `termCount` errors are visible in the same cycle as the inputs that cause them.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef struct packed {
    logic clear;
    logic step;
    logic goDown;
  } ctrl_strobes_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic          rst,
  input  logic          countUp,
  input  logic          countDown,
  output ctrl_strobes_t strobes
);
  always_comb begin
    strobes.clear  = rst;
    strobes.step   = countUp | countDown;
    strobes.goDown = ~countUp & countDown;
  end
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrl_strobes_t    strobes,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] srcBits;
  logic [WIDTH-1:0] toggleEn;
  logic [WIDTH:0]   chain;

  assign srcBits  = strobes.goDown ? ~stateQ : stateQ;
  assign chain[0] = strobes.step;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : gBit
      assign toggleEn[i] = chain[i];
      assign chain[i+1]  = chain[i] & srcBits[i];
      always_ff @(posedge clk) begin
        if (strobes.clear)    stateQ[i] <= 1'b0;
        else if (toggleEn[i]) stateQ[i] <= ~stateQ[i];
      end
    end
  endgenerate

  assign count     = stateQ;
  assign termCount = chain[WIDTH];
endmodule

// File: rtl/updn_toggle_counter.sv
module updn_toggle_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countUp,
  input  logic             countDown,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  ctrl_strobes_t strobes;

  updn_ctrl uCtrl (
    .rst(rst), .countUp(countUp), .countDown(countDown), .strobes(strobes)
  );

  updn_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .strobes(strobes), .count(count), .termCount(termCount)
  );
endmodule

// File: rtl/updn_checker.sv
module updn_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             countUp,
  input logic             countDown,
  input logic [WIDTH-1:0] count,
  input logic             termCount
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> count == '0);
  a_r2_r5_up: assert property (@(posedge clk) disable iff (rst || !started)
    countUp |=> count == $past(count) + 1'b1);
  a_r3_down: assert property (@(posedge clk) disable iff (rst || !started)
    (!countUp && countDown) |=> count == $past(count) - 1'b1);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst || !started)
    (!countUp && !countDown) |=> $stable(count));
  a_r6_lsb_flips: assert property (@(posedge clk) disable iff (rst || !started)
    (countUp || countDown) |=> count[0] != $past(count[0]));
  a_r8_tc_up: assert property (@(posedge clk) disable iff (rst)
    (countUp && (&count)) |-> termCount);
  a_r8_tc_down: assert property (@(posedge clk) disable iff (rst)
    (!countUp && countDown && count == '0) |-> termCount);
  a_r8_tc_hold: assert property (@(posedge clk) disable iff (rst)
    (!countUp && !countDown) |-> !termCount);
  a_r9_wrap_up: assert property (@(posedge clk) disable iff (rst || !started)
    termCount |=> (count == '0 || (&count)));
endmodule

bind updn_toggle_counter updn_checker #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rst(rst), .countUp(countUp), .countDown(countDown),
  .count(count), .termCount(termCount)
);

// File: tb/tb_updn_toggle_counter.sv
module tb_updn_toggle_counter;
  localparam int WIDTH = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << WIDTH) - 1;

  logic clk = 1'b0;
  logic rst, countUp, countDown;
  logic [WIDTH-1:0] count;
  logic termCount;
  int runs = 0, fails = 0;
  int model = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_toggle_counter #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .countUp(countUp), .countDown(countDown),
    .count(count), .termCount(termCount)
  );

  task automatic check(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive inputs after negedge, check tc, clock, check count
  task automatic step(bit r, bit u, bit d, string req);
    int expTc, prev;
    rst = r; countUp = u; countDown = d;
    #1;
    prev = model;
    if (r) expTc = -1;
    else if (u) expTc = (model == MAXV);
    else if (d) expTc = (model == 0);
    else expTc = 0;
    if (expTc >= 0) check("R8", int'(termCount), expTc);
    if (r) model = 0;
    else if (u) model = (model + 1) & MAXV;
    else if (d) model = (model - 1) & MAXV;
    @(posedge clk); #1;
    check(req, int'(count), model);
    if (!r && (u || d)) check("R6", int'(count[0]), (prev & 1) ^ 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; countUp = 1; countDown = 0;
    @(negedge clk);
    step(1, 1, 0, "R1");
    check("R1", int'(count), 0);
    for (int i = 0; i < 20; i++) step(0, 1, 0, "R2");   // wraps up: R9, R7
    for (int i = 0; i < 20; i++) step(0, 0, 1, "R3");   // wraps down: R9, R7
    for (int i = 0; i < 5; i++) step(0, 0, 0, "R4");
    for (int i = 0; i < 18; i++) step(0, 1, 1, "R5");
    // explicit wrap points
    while (model != MAXV) step(0, 1, 0, "R7");
    step(0, 1, 0, "R9");
    check("R9", int'(count), 0);
    step(0, 0, 1, "R9");
    check("R9", int'(count), MAXV);
    step(1, 1, 1, "R1");
    for (int i = 0; i < 2000; i++) begin
      int v = $urandom_range(0, 3);
      step(($urandom_range(0, 99) == 0), v[0], v[1], "R7");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule